// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a bank of byte-wide registers through a four-wire synchronous serial link with an active-low select. The serial clock, select and data input are brought into a fast system clock through flop synchronizers. All framing, shifting and register access runs in that system clock, so no logic is clocked by the serial clock. The system clock must run at least eight times faster than the serial clock.

Each transaction begins when the select goes low. The first byte is a header: its top bit chooses the direction and the low seven bits give the starting register address. One or more data bytes follow. After each data byte the address moves up by one, so a single select window can carry a burst. The serial output has a separate output enable so the pad floats while the block is not selected. A 128-entry register array inside the block, written in a form that maps onto block RAM, stands in for the register space.

Top module: `spi_regport`

## Requirements
- R1: While `spi_cs_n` is high, `spi_sdo_oe` is 0, at most three system clocks after `spi_cs_n` rises. While `spi_cs_n` is low, `spi_sdo_oe` is 1, at most three system clocks after `spi_cs_n` falls.
- R2: A header byte with bit 7 = 0 selects a write, and its bits 6..0 give the register address. The data byte that follows, sent MSB first and sampled on SCLK rising edges, is stored at that address.
- R3: A header byte with bit 7 = 1 selects a read. The addressed register is shifted out on `spi_sdo`, MSB first. Each bit changes only after an SCLK falling edge. The MSB appears after the falling edge that follows the 8th header bit.
- R4: In a write burst, data byte k (counting from 0) is stored at the header address plus k.
- R5: In a read burst, data byte k returns the register at the header address plus k.
- R6: The burst address wraps from 127 to 0, for both reads and writes.
- R7: A data byte that has fewer than 8 bits when `spi_cs_n` rises is discarded. No register changes, and bytes that completed earlier in the same burst are kept.
- R8: After reset, `spi_sdo_oe` and `spi_sdo` are both 0.
- R9: Raising `spi_cs_n` resets the framing, so the next transaction's first byte is always taken as a header, even after a truncated byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | Output enable for the `spi_sdo` pad driver |

## Verification
The hardest case to reach is a select rising in the middle of a byte, either inside a burst or right after a header. The register that byte pointed at must keep its old value, the earlier bytes must remain, and the next transaction must still parse a header. The bench uses a bit-level transfer task that can stop after any number of bits, so it builds truncated writes of different lengths and then reads the neighbouring registers back. Address wrap is reached with bursts that start a few registers below 127, after a full 128-byte burst has set every register to a computed pattern.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic {
    PH_HEADER = 1'b0,
    PH_DATA   = 1'b1
  } frame_phase_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic sdi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic selected,
  output logic sdi_sync
);
  logic [STAGES-1:0] sclk_q, cs_q, sdi_q;
  logic              sclk_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_q[s] <= 1'b0;
          cs_q[s]   <= 1'b1;
          sdi_q[s]  <= 1'b0;
        end else if (s == 0) begin
          sclk_q[s] <= sclk_in;
          cs_q[s]   <= cs_n_in;
          sdi_q[s]  <= sdi_in;
        end else begin
          sclk_q[s] <= sclk_q[s-1];
          cs_q[s]   <= cs_q[s-1];
          sdi_q[s]  <= sdi_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_q[STAGES-1];
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
  assign selected  = ~cs_q[STAGES-1];
  assign sdi_sync  = sdi_q[STAGES-1];
endmodule

// File: rtl/spi_regport_bank.sv
module spi_regport_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel,
  input  logic              sdi,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              bank_we,
  output logic              bank_re,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  frame_phase_e      phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr, rx_next, tx_sr;
  logic [ADDR_W-1:0] addr;
  logic              rd_mode, rd_pend;

  assign rx_next = {rx_sr[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_HEADER;
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      addr       <= '0;
      rd_mode    <= 1'b0;
      rd_pend    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
      bank_we    <= 1'b0;
      bank_re    <= 1'b0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
    end else begin
      bank_we <= 1'b0;
      bank_re <= 1'b0;
      rd_pend <= bank_re;
      sdo_oe  <= sel;
      if (rd_pend) tx_sr <= bank_rdata;
      if (!sel) begin
        phase   <= PH_HEADER;
        bit_cnt <= '0;
        rd_mode <= 1'b0;
      end else begin
        if (sclk_fall) begin
          sdo   <= tx_sr[DATA_W-1];
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
        if (sclk_rise) begin
          rx_sr   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= '0;
            if (phase == PH_HEADER) begin
              phase   <= PH_DATA;
              rd_mode <= rx_next[DATA_W-1];
              if (rx_next[DATA_W-1]) begin
                bank_re   <= 1'b1;
                bank_addr <= rx_next[ADDR_W-1:0];
                addr      <= rx_next[ADDR_W-1:0] + 1'b1;
              end else begin
                addr <= rx_next[ADDR_W-1:0];
              end
            end else begin
              bank_addr <= addr;
              addr      <= addr + 1'b1;
              if (rd_mode) bank_re <= 1'b1;
              else begin
                bank_we    <= 1'b1;
                bank_wdata <= rx_next;
              end
            end
          end
        end
      end
    end
  end

  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> $past(sel)); // R2
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bank_we && bank_re)); // R3
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(sclk_fall)); // R3
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> addr == ADDR_W'(bank_addr + 1'b1)); // R4
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    bank_re |-> addr == ADDR_W'(bank_addr + 1'b1)); // R5
  AST_DESEL_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !sel |=> bit_cnt == '0 && phase == PH_HEADER); // R9
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe
);
  logic              sclk_rise, sclk_fall, sel, sdi_s;
  logic [ADDR_W-1:0] bank_addr;
  logic [DATA_W-1:0] bank_wdata, bank_rdata;
  logic              bank_we, bank_re;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_in   (spi_sclk),
    .cs_n_in   (spi_cs_n),
    .sdi_in    (spi_sdi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .selected  (sel),
    .sdi_sync  (sdi_s)
  );

  spi_regport_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sel        (sel),
    .sdi        (sdi_s),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .bank_we    (bank_we),
    .bank_re    (bank_re),
    .bank_rdata (bank_rdata),
    .sdo        (spi_sdo),
    .sdo_oe     (spi_sdo_oe)
  );

  spi_regport_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .addr  (bank_addr),
    .wdata (bank_wdata),
    .we    (bank_we),
    .re    (bank_re),
    .rdata (bank_rdata)
  );

  AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_sdo_oe); // R1
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_sdi = 1'b0;
  logic spi_sdo, spi_sdo_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [128];
  logic [7:0] wbuf [256];

  always #4 clk = ~clk;

  spi_regport u_spi_regport (
    .clk        (clk),
    .rst        (rst),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_sdi    (spi_sdi),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic r);
    spi_sdi = b;
    wait_clk(HALF);
    spi_sclk = 1'b1;
    r = spi_sdo;
    wait_clk(HALF);
    spi_sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    logic b;
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      send_bit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic sel_on();
    @(negedge clk);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_off();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // writes n bytes from wbuf then optionally a truncated byte of tail bits
  task automatic burst_wr(input logic [6:0] a, input int n, input int tail);
    logic [7:0] rx;
    sel_on();
    xfer({1'b0, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], 8, rx);
      mdl[7'(a + k)] = wbuf[k];
    end
    if (tail > 0) xfer(8'hFF, tail, rx);
    sel_off();
  endtask

  task automatic burst_rd(input logic [6:0] a, input int n, input string req);
    logic [7:0] rx;
    sel_on();
    xfer({1'b1, a}, 8, rx);
    chk("R1 oe while selected", {7'd0, spi_sdo_oe}, 8'd1);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk(req, rx, mdl[7'(a + k)]);
    end
    sel_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(5);
    chk("R8 oe after reset", {7'd0, spi_sdo_oe}, 8'd0);
    chk("R8 sdo after reset", {7'd0, spi_sdo}, 8'd0);
    rst = 1'b0;
    wait_clk(4);
    chk("R1 oe idle", {7'd0, spi_sdo_oe}, 8'd0);

    // R4: one burst fills every register with an arithmetic pattern
    for (int k = 0; k < 128; k++) wbuf[k] = 8'(k * 37 + 11);
    burst_wr(7'd0, 128, 0);
    chk("R1 oe after deselect", {7'd0, spi_sdo_oe}, 8'd0);

    // R3/R4: single-byte reads of every register
    for (int a = 0; a < 128; a++) burst_rd(7'(a), 1, "R3 R4 single read");

    // R2: single-byte writes at scattered addresses
    for (int a = 0; a < 128; a += 9) begin
      wbuf[0] = 8'(a) ^ 8'hA5;
      burst_wr(7'(a), 1, 0);
    end
    for (int a = 0; a < 128; a += 3) burst_rd(7'(a), 1, "R2 single write readback");

    // R6: write and read bursts crossing 127 -> 0
    for (int k = 0; k < 6; k++) wbuf[k] = 8'hC0 + 8'(k);
    burst_wr(7'd125, 6, 0);
    burst_rd(7'd124, 8, "R5 R6 wrapping burst read");
    burst_rd(7'd60, 20, "R5 burst read");

    // R7/R9: truncated bytes of several lengths
    for (int t = 1; t < 8; t++) begin
      burst_wr(7'd10, 0, t);
      burst_rd(7'd10, 1, "R7 R9 truncated first byte");
    end
    wbuf[0] = 8'h3C;
    wbuf[1] = 8'h5A;
    burst_wr(7'd20, 2, 3);
    burst_rd(7'd20, 3, "R7 earlier bytes kept, partial dropped");
    burst_wr(7'd127, 0, 7);
    burst_rd(7'd127, 2, "R7 R9 header after truncation");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule